// File: doc/BRIEF.md
# Flag-Based Associative Search Engine

This block is a small content-addressable store of parameterised depth and width. Every word carries a match flag and an empty flag. The match flags persist after a search, so several searches can be chained: a later search can replace the flags, narrow them with AND, widen them with OR, or require a run of neighbouring words to match together. The lowest address always has the highest priority. The host reads the highest-priority flagged address, and can then step through the remaining flagged words one at a time. Words are written and read either by address or through their flags. A mask register excludes chosen bits from comparison, and from update during a write.

Every instruction takes three phases, in this order:
- The operands are captured into the block's registers.
- The array is acted on, and the result is latched.
- The result is presented to the host for one cycle.

The block accepts no new instruction while one is in flight. A refresh instruction spends one array cycle advancing a row counter. That counter models a periodic sweep over the storage rows. A refresh leaves the contents and the flags unchanged.

Top module: `cam_top`

## Requirements
- R1: An instruction is accepted on a rising edge where `instrValid` is high and `busy` is low. `busy` is high for the two cycles that follow, and `resultValid` is high only in the second of them. While `busy` is high, `instrValid` is ignored, so an instruction presented then has no effect.
- R2: After `rstN` is deasserted, every word is empty, every match flag is clear, the mask is zero and the refresh row is zero. A search then reports no hit.
- R3: Opcode 1 (search) sets each word's flag when that word is non-empty and equals the search data on every unmasked bit, and clears all other flags. The result carries `resultHit` (any flag set) and `resultAddr`, the lowest flagged address.
- R4: Opcode 13 loads the mask from `instrData`. A mask bit of 1 removes that data bit from comparison.
- R5: A write keeps the old value of every bit whose mask bit is 1, and takes the new data on the other bits.
- R6: Opcode 2 ANDs the new per-word result into the flags, and opcode 3 ORs it in. Both report the lowest flagged address.
- R7: Opcode 4 sets flag i only when words i through i+LINK_LEN-1 all match. A word with fewer than LINK_LEN-1 words above it is never flagged.
- R8: Opcode 5 clears the lowest set flag and reports the new lowest flag. When no flag remains, it reports no hit.
- R9: Opcode 6 reports the lowest empty address, or no hit when every word holds data. It leaves the flags unchanged.
- R10: Opcode 7 writes the word at `instrAddr` and clears its empty flag. Opcode 9 returns that word in `resultData`, with `resultHit` equal to "not empty". Opcode 8 writes every flagged word under the mask. Opcode 10 returns the data and address of the lowest flagged word.
- R11: Opcode 11 empties the addressed word, and opcode 12 empties every flagged word. An emptied word loses its flag and never matches a search.
- R12: Opcode 14 empties every word and clears every flag. A search for earlier data then misses, and a search for an empty word returns address 0.
- R13: Opcode 15 returns the current refresh row in `resultData` and advances the row, wrapping to 0 after REFRESH_ROWS (512) refreshes. Contents and flags are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous-free active-low reset, sampled on clk |
| instrValid | input | 1 | Instruction present |
| instrOp | input | 4 | Opcode (see requirements) |
| instrAddr | input | $clog2(WORDS) | Word address for addressed operations |
| instrData | input | WIDTH | Search, write or mask data |
| busy | output | 1 | Instruction in flight |
| resultValid | output | 1 | Result phase |
| resultHit | output | 1 | Hit / found indication |
| resultAddr | output | $clog2(WORDS) | Reported word address |
| resultData | output | WIDTH | Read data or refresh row |

## Verification
The assertions assume that the host never raises `instrValid` while `rstN` is low. They also assume that every opcode value may legally arrive, and that LINK_LEN is no larger than WORDS. The accept-and-sequence property further assumes that an instruction presented while busy is simply dropped. The stimulus issues one instruction at a time and waits for its result phase before the next. It presents an instruction during a busy phase in exactly one deliberate case, to show that the instruction is ignored.

// File: rtl/cam_pkg.sv
package cam_pkg;
  typedef enum logic [3:0] {
    OP_NOP        = 4'd0,
    OP_SRCH       = 4'd1,
    OP_SRCH_AND   = 4'd2,
    OP_SRCH_OR    = 4'd3,
    OP_SRCH_LINK  = 4'd4,
    OP_NEXT       = 4'd5,
    OP_FIND_EMPTY = 4'd6,
    OP_WR_ADDR    = 4'd7,
    OP_WR_MATCH   = 4'd8,
    OP_RD_ADDR    = 4'd9,
    OP_RD_MATCH   = 4'd10,
    OP_CLR_ADDR   = 4'd11,
    OP_CLR_MATCH  = 4'd12,
    OP_SET_MASK   = 4'd13,
    OP_FLUSH      = 4'd14,
    OP_REFRESH    = 4'd15
  } camOp_e;

  typedef enum logic [1:0] {CMB_LOAD, CMB_AND, CMB_OR, CMB_LINK} combine_e;

  typedef struct packed {
    logic     loadRegs;
    logic     act;
    logic     search;
    combine_e combine;
    logic     next;
    logic     findEmpty;
    logic     wrAddr;
    logic     wrMatch;
    logic     rdAddr;
    logic     rdMatch;
    logic     clrAddr;
    logic     clrMatch;
    logic     setMask;
    logic     flush;
    logic     refresh;
  } camStrobe_t;
endpackage

// File: rtl/cam_ctrl.sv
module cam_ctrl
  import cam_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       instrValid,
  input  logic [3:0] instrOp,
  output logic       busy,
  output logic       resultValid,
  output camStrobe_t strobes
);
  typedef enum logic [1:0] {ST_IDLE, ST_ACT, ST_OUT} phase_e;

  phase_e phase;
  camOp_e opReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= ST_IDLE;
      opReg <= OP_NOP;
    end else begin
      case (phase)
        ST_IDLE: if (instrValid) begin
          phase <= ST_ACT;
          opReg <= camOp_e'(instrOp);
        end
        ST_ACT:  phase <= ST_OUT;
        default: phase <= ST_IDLE;
      endcase
    end
  end

  assign busy        = (phase != ST_IDLE);
  assign resultValid = (phase == ST_OUT);

  always_comb begin
    strobes          = '0;
    strobes.loadRegs = (phase == ST_IDLE) && instrValid;
    if (phase == ST_ACT) begin
      strobes.act = 1'b1;
      case (opReg)
        OP_SRCH:       strobes.search = 1'b1;
        OP_SRCH_AND:   begin strobes.search = 1'b1; strobes.combine = CMB_AND;  end
        OP_SRCH_OR:    begin strobes.search = 1'b1; strobes.combine = CMB_OR;   end
        OP_SRCH_LINK:  begin strobes.search = 1'b1; strobes.combine = CMB_LINK; end
        OP_NEXT:       strobes.next      = 1'b1;
        OP_FIND_EMPTY: strobes.findEmpty = 1'b1;
        OP_WR_ADDR:    strobes.wrAddr    = 1'b1;
        OP_WR_MATCH:   strobes.wrMatch   = 1'b1;
        OP_RD_ADDR:    strobes.rdAddr    = 1'b1;
        OP_RD_MATCH:   strobes.rdMatch   = 1'b1;
        OP_CLR_ADDR:   strobes.clrAddr   = 1'b1;
        OP_CLR_MATCH:  strobes.clrMatch  = 1'b1;
        OP_SET_MASK:   strobes.setMask   = 1'b1;
        OP_FLUSH:      strobes.flush     = 1'b1;
        OP_REFRESH:    strobes.refresh   = 1'b1;
        default:       ;
      endcase
    end
  end
endmodule

// File: rtl/cam_array.sv
module cam_array
  import cam_pkg::*;
#(
  parameter int WORDS        = 16,
  parameter int WIDTH        = 16,
  parameter int LINK_LEN     = 2,
  parameter int REFRESH_ROWS = 512,
  localparam int AW          = $clog2(WORDS),
  localparam int RW          = $clog2(REFRESH_ROWS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  camStrobe_t       strobes,
  input  logic [AW-1:0]    instrAddr,
  input  logic [WIDTH-1:0] instrData,
  output logic             resultHit,
  output logic [AW-1:0]    resultAddr,
  output logic [WIDTH-1:0] resultData,
  output logic [WORDS-1:0] matchFlags,
  output logic [WORDS-1:0] emptyFlags
);
  logic [WIDTH-1:0] mem [WORDS];
  logic [WIDTH-1:0] maskReg, dataReg;
  logic [AW-1:0]    addrReg;
  logic [RW-1:0]    refreshRow;

  logic [WORDS-1:0] hitNow, linkHit, flagsNext, emptyNext, lowestBit;
  logic [AW:0]      curFirst, nextFirst, emptyFirst;
  logic             resHit;
  logic [AW-1:0]    resAddr;
  logic [WIDTH-1:0] resData;

  // lowest index wins; result is {found, index}
  function automatic logic [AW:0] firstOf(input logic [WORDS-1:0] v);
    firstOf = '0;
    for (int k = WORDS - 1; k >= 0; k--)
      if (v[k]) firstOf = {1'b1, AW'(k)};
  endfunction

  function automatic logic [WIDTH-1:0] merge(input logic [WIDTH-1:0] old);
    merge = (old & maskReg) | (dataReg & ~maskReg);
  endfunction

  for (genvar i = 0; i < WORDS; i++) begin : g_word
    assign hitNow[i] = !emptyFlags[i] && (((mem[i] ^ dataReg) & ~maskReg) == '0);
    if (i + LINK_LEN <= WORDS) begin : g_link
      assign linkHit[i] = &hitNow[i +: LINK_LEN];
    end else begin : g_edge
      assign linkHit[i] = 1'b0;
    end
  end

  assign lowestBit  = matchFlags & (~matchFlags + WORDS'(1));
  assign curFirst   = firstOf(matchFlags);
  assign nextFirst  = firstOf(flagsNext);
  assign emptyFirst = firstOf(emptyFlags);

  always_comb begin
    flagsNext = matchFlags;
    emptyNext = emptyFlags;
    if (strobes.search) begin
      case (strobes.combine)
        CMB_AND:  flagsNext = matchFlags & hitNow;
        CMB_OR:   flagsNext = matchFlags | hitNow;
        CMB_LINK: flagsNext = linkHit;
        default:  flagsNext = hitNow;
      endcase
    end
    if (strobes.next)     flagsNext = matchFlags & ~lowestBit;
    if (strobes.wrAddr)   emptyNext[addrReg] = 1'b0;
    if (strobes.wrMatch)  emptyNext = emptyFlags & ~matchFlags;
    if (strobes.clrAddr) begin
      emptyNext[addrReg] = 1'b1;
      flagsNext[addrReg] = 1'b0;
    end
    if (strobes.clrMatch) begin
      emptyNext = emptyFlags | matchFlags;
      flagsNext = '0;
    end
    if (strobes.flush) begin
      emptyNext = '1;
      flagsNext = '0;
    end
  end

  always_comb begin
    resHit  = 1'b0;
    resAddr = '0;
    resData = '0;
    if (strobes.search || strobes.next)  {resHit, resAddr} = nextFirst;
    if (strobes.findEmpty)               {resHit, resAddr} = emptyFirst;
    if (strobes.wrAddr || strobes.clrAddr) begin
      resHit  = 1'b1;
      resAddr = addrReg;
    end
    if (strobes.rdAddr) begin
      resHit  = !emptyFlags[addrReg];
      resAddr = addrReg;
      resData = mem[addrReg];
    end
    if (strobes.wrMatch || strobes.clrMatch || strobes.rdMatch) {resHit, resAddr} = curFirst;
    if (strobes.rdMatch)  resData = mem[curFirst[AW-1:0]];
    if (strobes.refresh)  resData = WIDTH'(refreshRow);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < WORDS; i++) mem[i] <= '0;
      matchFlags <= '0;
      emptyFlags <= '1;
      maskReg    <= '0;
      dataReg    <= '0;
      addrReg    <= '0;
      refreshRow <= '0;
      resultHit  <= 1'b0;
      resultAddr <= '0;
      resultData <= '0;
    end else begin
      if (strobes.loadRegs) begin
        dataReg <= instrData;
        addrReg <= instrAddr;
      end
      matchFlags <= flagsNext;
      emptyFlags <= emptyNext;
      for (int i = 0; i < WORDS; i++)
        if ((strobes.wrAddr && addrReg == AW'(i)) || (strobes.wrMatch && matchFlags[i]))
          mem[i] <= merge(mem[i]);
      if (strobes.setMask) maskReg <= dataReg;
      if (strobes.refresh)
        refreshRow <= (refreshRow == RW'(REFRESH_ROWS - 1)) ? '0 : refreshRow + RW'(1);
      if (strobes.act) begin
        resultHit  <= resHit;
        resultAddr <= resAddr;
        resultData <= resData;
      end
    end
  end
endmodule

// File: rtl/cam_top.sv
module cam_top
  import cam_pkg::*;
#(
  parameter int WORDS        = 16,
  parameter int WIDTH        = 16,
  parameter int LINK_LEN     = 2,
  parameter int REFRESH_ROWS = 512,
  localparam int AW          = $clog2(WORDS)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             instrValid,
  input  logic [3:0]       instrOp,
  input  logic [AW-1:0]    instrAddr,
  input  logic [WIDTH-1:0] instrData,
  output logic             busy,
  output logic             resultValid,
  output logic             resultHit,
  output logic [AW-1:0]    resultAddr,
  output logic [WIDTH-1:0] resultData
);
  camStrobe_t       strobes;
  logic [WORDS-1:0] matchFlags;
  logic [WORDS-1:0] emptyFlags;

  cam_ctrl ctrl_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrOp(instrOp),
    .busy(busy), .resultValid(resultValid), .strobes(strobes)
  );

  cam_array #(
    .WORDS(WORDS), .WIDTH(WIDTH), .LINK_LEN(LINK_LEN), .REFRESH_ROWS(REFRESH_ROWS)
  ) array_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .instrAddr(instrAddr), .instrData(instrData),
    .resultHit(resultHit), .resultAddr(resultAddr), .resultData(resultData),
    .matchFlags(matchFlags), .emptyFlags(emptyFlags)
  );
endmodule

// File: rtl/cam_top_checker.sv
module cam_top_checker #(
  parameter int WORDS = 16
) (
  input logic             clk,
  input logic             rstN,
  input logic             instrValid,
  input logic             busy,
  input logic             resultValid,
  input logic             doNext,
  input logic             doFlush,
  input logic             doRefresh,
  input logic [WORDS-1:0] matchFlags,
  input logic [WORDS-1:0] emptyFlags
);
  p_accept_sequence_r1: assert property (@(posedge clk) disable iff (!rstN)
    (instrValid && !busy) |=> (busy && !resultValid) ##1 (busy && resultValid));

  p_result_single_r1: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> (!resultValid && !busy));

  p_empty_unflagged_r11: assert property (@(posedge clk) disable iff (!rstN)
    (matchFlags & emptyFlags) == '0);

  p_next_pops_one_r8: assert property (@(posedge clk) disable iff (!rstN)
    (doNext && matchFlags != '0) |=> $countones(matchFlags) == $countones($past(matchFlags)) - 1);

  p_flush_clears_r12: assert property (@(posedge clk) disable iff (!rstN)
    doFlush |=> (matchFlags == '0) && (&emptyFlags));

  p_refresh_keeps_flags_r13: assert property (@(posedge clk) disable iff (!rstN)
    doRefresh |=> ($stable(matchFlags) && $stable(emptyFlags)));
endmodule

bind cam_top cam_top_checker #(.WORDS(WORDS)) chk_i (
  .clk(clk), .rstN(rstN), .instrValid(instrValid), .busy(busy),
  .resultValid(resultValid), .doNext(strobes.next), .doFlush(strobes.flush),
  .doRefresh(strobes.refresh), .matchFlags(matchFlags), .emptyFlags(emptyFlags)
);

// File: tb/cam_top_tb_top.sv
`timescale 1ns/1ps
module cam_top_tb_top;
  localparam int WORDS = 16;
  localparam int WIDTH = 16;
  localparam int AW    = 4;

  localparam logic [3:0] SRCH = 4'd1, SRCH_AND = 4'd2, SRCH_OR = 4'd3, SRCH_LINK = 4'd4,
    NEXT = 4'd5, FIND_EMPTY = 4'd6, WR_ADDR = 4'd7, WR_MATCH = 4'd8, RD_ADDR = 4'd9,
    RD_MATCH = 4'd10, CLR_ADDR = 4'd11, CLR_MATCH = 4'd12, SET_MASK = 4'd13,
    FLUSH = 4'd14, REFRESH = 4'd15;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             instrValid = 1'b0;
  logic [3:0]       instrOp = '0;
  logic [AW-1:0]    instrAddr = '0;
  logic [WIDTH-1:0] instrData = '0;
  logic             busy, resultValid, resultHit;
  logic [AW-1:0]    resultAddr;
  logic [WIDTH-1:0] resultData;

  int checks = 0;
  int failures = 0;
  logic             rValid, rHit;
  logic [AW-1:0]    rAddr;
  logic [WIDTH-1:0] rData;

  always #4 clk = ~clk;

  cam_top #(.WORDS(WORDS), .WIDTH(WIDTH), .LINK_LEN(2), .REFRESH_ROWS(512)) dut_i (
    .clk(clk), .rstN(rstN), .instrValid(instrValid), .instrOp(instrOp),
    .instrAddr(instrAddr), .instrData(instrData), .busy(busy),
    .resultValid(resultValid), .resultHit(resultHit), .resultAddr(resultAddr),
    .resultData(resultData)
  );

  task automatic check(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic doOp(input logic [3:0] op, input logic [AW-1:0] a, input logic [WIDTH-1:0] d);
    @(negedge clk);
    instrValid = 1'b1; instrOp = op; instrAddr = a; instrData = d;
    @(posedge clk);
    @(negedge clk);
    instrValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    rValid = resultValid; rHit = resultHit; rAddr = resultAddr; rData = resultData;
    @(posedge clk);
  endtask

  task automatic t_reset_r2;
    check("R2", "busy after reset", {31'd0, busy}, 32'd0);
    check("R2", "resultValid after reset", {31'd0, resultValid}, 32'd0);
    doOp(SRCH, '0, 16'h0000);
    check("R2", "search on empty store", {31'd0, rHit}, 32'd0);
    doOp(FIND_EMPTY, '0, '0);
    check("R2", "all empty, first empty", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd0});
  endtask

  task automatic t_busy_r1;
    @(negedge clk);
    instrValid = 1'b1; instrOp = RD_ADDR; instrAddr = 4'd0; instrData = '0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "act phase busy/valid", {30'd0, busy, resultValid}, {30'd0, 2'b10});
    instrOp = WR_ADDR; instrData = 16'hFFFF;  // presented while busy
    @(posedge clk);
    @(negedge clk);
    check("R1", "result phase busy/valid", {30'd0, busy, resultValid}, {30'd0, 2'b11});
    instrValid = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R1", "back to idle", {30'd0, busy, resultValid}, 32'd0);
    doOp(RD_ADDR, 4'd0, '0);
    check("R1", "instruction during busy ignored", {31'd0, rHit}, 32'd0);
  endtask

  task automatic t_write_read_r10;
    doOp(WR_ADDR, 4'd3, 16'h1234);
    check("R10", "write result valid", {31'd0, rValid}, 32'd1);
    doOp(WR_ADDR, 4'd5, 16'hABCD);
    doOp(WR_ADDR, 4'd7, 16'h1234);
    doOp(RD_ADDR, 4'd3, '0);
    check("R10", "read addr 3", {15'd0, rHit, rData}, {15'd0, 1'b1, 16'h1234});
    doOp(RD_ADDR, 4'd4, '0);
    check("R10", "read empty addr 4", {31'd0, rHit}, 32'd0);
  endtask

  task automatic t_search_r3;
    doOp(SRCH, '0, 16'h1234);
    check("R3", "search 1234", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd3});
    doOp(SRCH, '0, 16'h9999);
    check("R3", "search miss", {31'd0, rHit}, 32'd0);
  endtask

  task automatic t_mask_r4_r5;
    doOp(SET_MASK, '0, 16'h00FF);
    doOp(SRCH, '0, 16'h12FF);
    check("R4", "masked search high byte", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd3});
    doOp(WR_ADDR, 4'd5, 16'h5555);
    doOp(RD_ADDR, 4'd5, '0);
    check("R5", "partial write keeps masked bits", {16'd0, rData}, {16'd0, 16'h55CD});
    doOp(SET_MASK, '0, 16'h0000);
  endtask

  task automatic t_next_r8_r9;
    doOp(SRCH, '0, 16'h1234);
    check("R8", "first match", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd3});
    doOp(FIND_EMPTY, '0, '0);
    check("R9", "lowest empty", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd0});
    doOp(NEXT, '0, '0);
    check("R8", "next after 3 (flags kept by R9)", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd7});
    doOp(NEXT, '0, '0);
    check("R8", "next exhausted", {31'd0, rHit}, 32'd0);
  endtask

  task automatic t_and_or_r6;
    doOp(SRCH, '0, 16'h1234);
    doOp(SRCH_OR, '0, 16'h55CD);
    check("R6", "OR search lowest", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd3});
    doOp(NEXT, '0, '0);
    check("R6", "OR keeps word 5", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd5});
    doOp(NEXT, '0, '0);
    check("R6", "OR keeps word 7", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd7});
    doOp(SRCH, '0, 16'h1234);
    doOp(SRCH_OR, '0, 16'h55CD);
    doOp(SET_MASK, '0, 16'hFFF0);
    doOp(SRCH_AND, '0, 16'h000D);
    check("R6", "AND narrows to word 5", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd5});
    doOp(NEXT, '0, '0);
    check("R6", "AND left one flag", {31'd0, rHit}, 32'd0);
    doOp(SET_MASK, '0, 16'h0000);
  endtask

  task automatic t_link_r7;
    doOp(WR_ADDR, 4'd8, 16'hAAAA);
    doOp(WR_ADDR, 4'd9, 16'hAAAA);
    doOp(WR_ADDR, 4'd10, 16'hAAAA);
    doOp(WR_ADDR, 4'd15, 16'hAAAA);
    doOp(SRCH_LINK, '0, 16'hAAAA);
    check("R7", "link first", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd8});
    doOp(NEXT, '0, '0);
    check("R7", "link second", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd9});
    doOp(NEXT, '0, '0);
    check("R7", "run end and top word unflagged", {31'd0, rHit}, 32'd0);
  endtask

  task automatic t_write_matched_r10;
    doOp(SRCH, '0, 16'hAAAA);
    doOp(SET_MASK, '0, 16'hFF00);
    doOp(WR_MATCH, '0, 16'h0055);
    doOp(SET_MASK, '0, 16'h0000);
    doOp(RD_ADDR, 4'd15, '0);
    check("R10", "write matched word 15", {16'd0, rData}, {16'd0, 16'hAA55});
    doOp(RD_ADDR, 4'd10, '0);
    check("R10", "write matched word 10", {16'd0, rData}, {16'd0, 16'hAA55});
    doOp(SRCH, '0, 16'hAA55);
    doOp(RD_MATCH, '0, '0);
    check("R10", "read matched", {11'd0, rHit, rAddr, rData}, {11'd0, 1'b1, 4'd8, 16'hAA55});
  endtask

  task automatic t_empty_r11;
    doOp(CLR_ADDR, 4'd8, '0);
    doOp(SRCH, '0, 16'hAA55);
    check("R11", "emptied word skipped", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd9});
    doOp(CLR_MATCH, '0, '0);
    doOp(SRCH, '0, 16'hAA55);
    check("R11", "matched words emptied", {31'd0, rHit}, 32'd0);
    doOp(RD_ADDR, 4'd15, '0);
    check("R11", "word 15 now empty", {31'd0, rHit}, 32'd0);
  endtask

  task automatic t_refresh_r13;
    int bad = 0;
    doOp(SRCH, '0, 16'h1234);
    for (int n = 0; n < 513; n++) begin
      doOp(REFRESH, '0, '0);
      if (rData !== WIDTH'(n % 512)) bad++;
    end
    check("R13", "refresh row sequence and wrap", bad, 32'd0);
    check("R13", "row after wrap", {16'd0, rData}, 32'd0);
    doOp(RD_MATCH, '0, '0);
    check("R13", "flags and data kept", {11'd0, rHit, rAddr, rData}, {11'd0, 1'b1, 4'd3, 16'h1234});
  endtask

  task automatic t_full_flush_r9_r12;
    for (int i = 0; i < WORDS; i++) doOp(WR_ADDR, AW'(i), 16'h0100 + 16'(i));
    doOp(FIND_EMPTY, '0, '0);
    check("R9", "no empty word when full", {31'd0, rHit}, 32'd0);
    doOp(FLUSH, '0, '0);
    doOp(SRCH, '0, 16'h0103);
    check("R12", "search after flush", {31'd0, rHit}, 32'd0);
    doOp(FIND_EMPTY, '0, '0);
    check("R12", "empty after flush", {27'd0, rHit, rAddr}, {27'd0, 1'b1, 4'd0});
    doOp(RD_ADDR, 4'd3, '0);
    check("R12", "read after flush", {31'd0, rHit}, 32'd0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset_r2();
    t_busy_r1();
    t_write_read_r10();
    t_search_r3();
    t_mask_r4_r5();
    t_next_r8_r9();
    t_and_or_r6();
    t_link_r7();
    t_write_matched_r10();
    t_empty_r11();
    t_refresh_r13();
    t_full_flush_r9_r12();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog: run did not complete");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule